// File: doc/BRIEF.md
# SDRAM Burst Read Output Tracker

This block follows the read data path of a four-bank synchronous DRAM one clock at a time, from the controller side. It watches the read and precharge strobes together with the bank address. From them it predicts, for every cycle, whether a data word is on the bus and which word of the burst it is. It also raises a one-cycle pulse with the last word of each burst. The CAS latency and the burst length come in as configuration inputs.

A precharge to the bank being read ends the burst early. The output turns off one CAS latency after the precharge, so the number of words delivered equals the number of clocks between the read and the precharge, up to the full burst length. A precharge to another bank, or one that comes after every word has already been issued, leaves the burst unchanged. A precharge given in the same cycle as the read breaks the protocol. It is flagged and then ignored.

Top module: `sdram_rd_tracker`

## Requirements
- R1: With CAS latency L of 2 or 3, an accepted read puts word 0 on the outputs (`dq_valid`=1, `beat_idx`=0) exactly L clocks after the read is sampled.
- R2: A read without an interrupting precharge yields four valid words on consecutive cycles, with indices 0, 1, 2, 3, and `dq_valid` is low on the next cycle.
- R3: A precharge to the bank being read, sampled d clocks after the read (1 ≤ d ≤ 3), limits the burst to d words (indices 0 to d-1). `dq_valid` falls L clocks after the precharge.
- R4: A precharge to any other bank does not change the burst in progress.
- R5: A precharge to the same bank sampled 4 or more clocks after the read, when all four words have been issued, leaves the full burst intact.
- R6: `burst_done` is high for exactly one cycle, on the cycle of the last valid word of a burst, whether the burst was cut or ran in full. It is never high without `dq_valid`.
- R7: When read and precharge are both strobed in one cycle, `proto_err` is high for the following cycle, the precharge has no effect, and the read delivers a full burst.
- R8: A CAS latency other than 2 or 3, or a burst length other than 4 on `cfg_bl`, sets `cfg_err` one clock later. Reads strobed under such a setting produce no output words.
- R9: A synchronous reset clears every pending word. All outputs are low after the reset edge and stay low once reset is released, with no new read.
- R10: `beat_idx` is 0 whenever `dq_valid` is low. Within a burst it rises by one from each valid word to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_req | input | 1 | Read command strobe |
| pre_req | input | 1 | Precharge command strobe |
| bank | input | 2 | Bank address for the strobed command |
| cfg_cl | input | 2 | CAS latency in clocks (2 or 3 accepted) |
| cfg_bl | input | 4 | Burst length in words (4 accepted) |
| dq_valid | output | 1 | A read word is on the data bus this cycle |
| beat_idx | output | 2 | Position in the burst of the word on the bus |
| burst_done | output | 1 | Last word of the current burst |
| proto_err | output | 1 | Read and precharge were strobed together in the previous cycle |
| cfg_err | output | 1 | The configuration sampled in the previous cycle is not supported |

## Verification
The bench steps the read-to-precharge spacing from one clock up to past the burst length under both latencies. An off-by-one in the cut point shows up here as one word too many or too few, or as the bus turning off on the wrong cycle. Precharges to a different bank and precharges given together with the read are mixed in. A tracker that decodes the bank carelessly, or that honours an illegal precharge, would wrongly shorten those bursts. Further tests check that the done pulse lands on the final word of a cut burst and not one cycle late. They also check that unsupported latency or length settings never produce data, and that a reset in the middle of a burst leaves nothing in flight.

// File: rtl/sdrt_pkg.sv
package sdrt_pkg;
  localparam int BURST_LEN = 4;
  localparam int BEAT_W    = $clog2(BURST_LEN);
  localparam int BL_W      = 4;
  localparam int CL_MIN    = 2;

  typedef struct packed {
    logic              vld;
    logic              last;
    logic [BEAT_W-1:0] idx;
  } beat_t;
endpackage

// File: rtl/sdrt_cfg_chk.sv
module sdrt_cfg_chk
  import sdrt_pkg::*;
#(
  parameter int CL_MAX = 3,
  localparam int CLW = $clog2(CL_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CLW-1:0]  cfg_cl,
  input  logic [BL_W-1:0] cfg_bl,
  output logic            cfg_ok,
  output logic            cfg_err
);
  always_comb begin
    cfg_ok = (cfg_cl >= CLW'(CL_MIN)) && (cfg_cl <= CLW'(CL_MAX)) &&
             (cfg_bl == BL_W'(BURST_LEN));
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= ~cfg_ok;
  end
endmodule

// File: rtl/sdrt_beat_gen.sv
module sdrt_beat_gen
  import sdrt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              pre_req,
  input  logic [BANK_W-1:0] bank,
  input  logic              cfg_ok,
  output beat_t             push,
  output logic              cut,
  output logic              proto_err
);
  logic              active_q;
  logic [BANK_W-1:0] bank_q;
  logic [BEAT_W-1:0] next_q;
  logic              rd_ok;
  logic              pre_hit;

  always_comb begin
    rd_ok   = rd_req & cfg_ok;
    pre_hit = active_q & pre_req & ~rd_req & (bank == bank_q);
    // a restarted read also closes the burst that was still issuing
    cut     = pre_hit | (active_q & rd_ok);
    push    = '0;
    if (rd_ok) begin
      push.vld  = 1'b1;
      push.last = (BURST_LEN == 1);
      push.idx  = '0;
    end else if (active_q && !pre_hit) begin
      push.vld  = 1'b1;
      push.last = (next_q == BEAT_W'(BURST_LEN - 1));
      push.idx  = next_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      bank_q    <= '0;
      next_q    <= '0;
      proto_err <= 1'b0;
    end else begin
      proto_err <= rd_req & pre_req;
      if (rd_ok) begin
        active_q <= (BURST_LEN > 1);
        bank_q   <= bank;
        next_q   <= BEAT_W'(1);
      end else if (pre_hit) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        next_q <= next_q + 1'b1;
        if (push.last) active_q <= 1'b0;
      end
    end
  end

  assert_pre_hit_stops_R3: assert property (@(posedge clk) disable iff (rst)
    pre_hit |=> !active_q);
  assert_joint_pre_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_req && pre_req && cfg_ok) |=> active_q);
  assert_bad_cfg_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !cfg_ok && !active_q) |=> !active_q);
endmodule

// File: rtl/sdrt_lat_pipe.sv
module sdrt_lat_pipe
  import sdrt_pkg::*;
#(
  parameter int CL_MAX = 3,
  localparam int CLW = $clog2(CL_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  beat_t          push,
  input  logic           cut,
  input  logic [CLW-1:0] cfg_cl,
  input  logic           cfg_ok,
  output logic           dq_valid,
  output logic [BEAT_W-1:0] beat_idx,
  output logic           burst_done
);
  beat_t stg [1:CL_MAX];
  beat_t sel;

  always_ff @(posedge clk) begin
    if (rst) stg[1] <= '0;
    else     stg[1] <= push;
  end

  for (genvar g = 2; g <= CL_MAX; g++) begin : g_stage
    if (g == 2) begin : g_mark
      // the word issued just before a cut becomes the final one
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else begin
          stg[g]      <= stg[g-1];
          stg[g].last <= stg[g-1].last | (stg[g-1].vld & cut);
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  always_comb begin
    sel = '0;
    for (int k = CL_MIN; k <= CL_MAX; k++) begin
      if (cfg_ok && cfg_cl == CLW'(k)) sel = stg[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_valid   <= 1'b0;
      beat_idx   <= '0;
      burst_done <= 1'b0;
    end else begin
      dq_valid   <= sel.vld;
      beat_idx   <= sel.vld ? sel.idx : '0;
      burst_done <= sel.vld & sel.last;
    end
  end

  assert_done_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
    burst_done |-> dq_valid);
  assert_idle_idx_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !dq_valid |-> beat_idx == '0);
  assert_idx_steps_R10: assert property (@(posedge clk) disable iff (rst)
    (dq_valid && !burst_done && $stable(cfg_cl)) |=>
      (dq_valid && beat_idx == $past(beat_idx) + 1'b1));
endmodule

// File: rtl/sdram_rd_tracker.sv
module sdram_rd_tracker
  import sdrt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CL_MAX    = 3,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int CLW    = $clog2(CL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              pre_req,
  input  logic [BANK_W-1:0] bank,
  input  logic [CLW-1:0]    cfg_cl,
  input  logic [BL_W-1:0]   cfg_bl,
  output logic              dq_valid,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              burst_done,
  output logic              proto_err,
  output logic              cfg_err
);
  logic  cfg_ok;
  logic  cut;
  beat_t push;

  sdrt_cfg_chk #(.CL_MAX(CL_MAX)) u_cfg (
    .clk(clk), .rst(rst), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl),
    .cfg_ok(cfg_ok), .cfg_err(cfg_err)
  );

  sdrt_beat_gen #(.NUM_BANKS(NUM_BANKS)) u_gen (
    .clk(clk), .rst(rst), .rd_req(rd_req), .pre_req(pre_req), .bank(bank),
    .cfg_ok(cfg_ok), .push(push), .cut(cut), .proto_err(proto_err)
  );

  sdrt_lat_pipe #(.CL_MAX(CL_MAX)) u_pipe (
    .clk(clk), .rst(rst), .push(push), .cut(cut), .cfg_cl(cfg_cl),
    .cfg_ok(cfg_ok), .dq_valid(dq_valid), .beat_idx(beat_idx),
    .burst_done(burst_done)
  );

  assert_err_flag_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(rd_req && pre_req));
endmodule

// File: tb/sim_sdram_rd_tracker.sv
module sim_sdram_rd_tracker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_req = 1'b0, pre_req = 1'b0;
  logic [1:0] bank = '0;
  logic [1:0] cfg_cl = 2'd2;
  logic [3:0] cfg_bl = 4'd4;
  logic       dq_valid, burst_done, proto_err, cfg_err;
  logic [1:0] beat_idx;
  int         checks = 0, fails = 0;

  always #2 clk = ~clk;

  sdram_rd_tracker u0 (
    .clk(clk), .rst(rst), .rd_req(rd_req), .pre_req(pre_req), .bank(bank),
    .cfg_cl(cfg_cl), .cfg_bl(cfg_bl), .dq_valid(dq_valid), .beat_idx(beat_idx),
    .burst_done(burst_done), .proto_err(proto_err), .cfg_err(cfg_err)
  );

  // {cl[2], pre delay[3] (0 = none), other bank, joint with read, expected words[3]}
  localparam logic [9:0] VEC [0:13] = '{
    {2'd2, 3'd0, 1'b0, 1'b0, 3'd4}, {2'd3, 3'd0, 1'b0, 1'b0, 3'd4},
    {2'd2, 3'd1, 1'b0, 1'b0, 3'd1}, {2'd2, 3'd2, 1'b0, 1'b0, 3'd2},
    {2'd2, 3'd3, 1'b0, 1'b0, 3'd3}, {2'd3, 3'd1, 1'b0, 1'b0, 3'd1},
    {2'd3, 3'd2, 1'b0, 1'b0, 3'd2}, {2'd3, 3'd3, 1'b0, 1'b0, 3'd3},
    {2'd2, 3'd4, 1'b0, 1'b0, 3'd4}, {2'd3, 3'd5, 1'b0, 1'b0, 3'd4},
    {2'd2, 3'd2, 1'b1, 1'b0, 3'd4}, {2'd3, 3'd1, 1'b1, 1'b0, 3'd4},
    {2'd2, 3'd0, 1'b0, 1'b1, 3'd4}, {2'd3, 3'd0, 1'b0, 1'b1, 3'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_outputs(input string req);
    chk(dq_valid == 1'b0, req, dq_valid, 0);
    chk(burst_done == 1'b0, req, burst_done, 0);
    chk(beat_idx == 2'd0, req, beat_idx, 0);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: state after reset
    idle_outputs("R9");
    chk(proto_err == 1'b0 && cfg_err == 1'b0, "R9", {proto_err, cfg_err}, 0);

    for (int v = 0; v < 14; v++) begin
      logic [1:0] cl;
      logic [2:0] dly;
      logic       oth, both;
      int         n;
      string      req;
      {cl, dly, oth, both} = VEC[v][9:3];
      n = int'(VEC[v][2:0]);
      req = both ? "R7" : oth ? "R4" : (dly == 0) ? "R2" : (dly >= 4) ? "R5" : "R3";
      cfg_cl = cl;
      repeat (2) @(negedge clk);
      rd_req = 1'b1; bank = 2'd1; pre_req = both;
      @(posedge clk);
      for (int j = 0; j < 12; j++) begin
        bit ev, ed;
        @(negedge clk);
        ev = (j >= cl) && (j < cl + n);
        ed = (j == cl + n - 1);
        chk(dq_valid == ev, req, dq_valid, ev);
        if (ev) chk(beat_idx == 2'(j - cl), "R10", beat_idx, j - cl);
        else    chk(beat_idx == 2'd0, "R10", beat_idx, 0);
        chk(burst_done == ed, "R6", burst_done, ed);
        if (j == cl) chk(dq_valid && beat_idx == 0, "R1", {dq_valid, beat_idx}, 4);
        if (j == 0)  chk(proto_err == both, "R7", proto_err, both);
        if (j == 1)  chk(proto_err == 1'b0, "R7", proto_err, 0);
        rd_req = 1'b0;
        pre_req = (dly != 0) && (j + 1 == dly);
        bank = oth ? 2'd2 : 2'd1;
      end
      pre_req = 1'b0;
    end

    // R8: unsupported latency, then unsupported length
    for (int c = 0; c < 2; c++) begin
      cfg_cl = (c == 0) ? 2'd1 : 2'd3;
      cfg_bl = (c == 0) ? 4'd4 : 4'd8;
      @(negedge clk);
      rd_req = 1'b1; bank = 2'd0;
      @(negedge clk);
      rd_req = 1'b0;
      chk(cfg_err == 1'b1, "R8", cfg_err, 1);
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        chk(dq_valid == 1'b0, "R8", dq_valid, 0);
      end
    end
    cfg_cl = 2'd3; cfg_bl = 4'd4;
    @(negedge clk);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R8", cfg_err, 0);

    // R9: reset in the middle of a burst drops pending words
    cfg_cl = 2'd2;
    @(negedge clk);
    rd_req = 1'b1; bank = 2'd3;
    @(negedge clk);
    rd_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(dq_valid == 1'b1, "R9", dq_valid, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle_outputs("R9");
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      idle_outputs("R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule